// File: doc/BRIEF.md
# Dual-Compare 8-Bit Event Timer

This block is an 8-bit up-counter that advances by one on each cycle where a count tick is present. Two compare registers, A and B, are checked against the counter on every tick, and the counter also reports when it wraps from its top value back to zero. A two-bit select field decides what, if anything, returns the counter to zero: nothing, a match on A, a match on B, or an external reset pin. The pin can act on its rising edge or on its level.

Each of the three events (wrap, match A, match B) latches a status flag, whether or not its interrupt is enabled. Software clears a flag by writing a 0 to its bit. Each interrupt output is its flag gated by an enable bit in the control register. All state is reached through a small synchronous write port with a combinational read-back.

Top module: `dct_timer`

## Requirements
- R1: After reset every register reads 0 and all three interrupt outputs are low. Register addresses: 0 control, 1 mode, 2 counter, 3 compare A, 4 compare B, 5 flags, and every other address reads 0.
- R2: Control bits [2:0] always read 0, and writes to them are ignored. Control bits [7:3] read back as written.
- R3: With no clear and no counter write, the counter rises by exactly 1 on each tick and holds its value on cycles without a tick.
- R4: A tick with the counter at 0xFF and no other clear or write makes the counter 0x00 and sets flag bit 0 (overflow).
- R5: A tick while the counter equals compare A sets flag bit 1, and a tick while it equals compare B sets flag bit 2. This happens even while the matching interrupt is disabled.
- R6: Control bits [4:3] select the clear: 00 none, 01 match A, 10 match B. On a tick with the selected match, the counter becomes 0 instead of incrementing, so the period is compare+1 ticks. A clear of this kind, even from 0xFF, does not set the overflow flag.
- R7: With select 11 and mode bit 0 = 0 (edge), a rising edge on the external pin, after two synchronizer stages, clears the counter once. Counting resumes while the pin stays high.
- R8: With select 11 and mode bit 0 = 1 (level), the counter is held at 0 for as long as the synchronized pin is high.
- R9: The overflow, match A and match B interrupt outputs equal flag bits 0, 1 and 2 ANDed with control bits 5, 6 and 7.
- R10: Writing to address 5 clears each flag bit written as 0 and leaves bits written as 1 unchanged. An event in the same cycle sets its flag regardless of the write.
- R11: A write to the counter takes priority over a tick and over any clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| tick | input | 1 | Count enable for this cycle |
| ext_clr | input | 1 | Asynchronous external counter reset pin |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cma | output | 1 | Compare A interrupt request |
| irq_cmb | output | 1 | Compare B interrupt request |

## Verification
The assertions check on every cycle the rules that involve only adjacent cycles: a counter write lands next cycle, the counter holds without a tick or clear, the counter wraps and clears on a selected match, the level-mode hold, and the masking of each interrupt by its enable. Some behaviour spans several cycles, and only the bench scenarios can show it. This covers the full period of compare+1 ticks, a single clear per pin edge while counting continues, the effect of the synchronizer delay, the write-one-to-keep flag semantics, and the absence of an overflow flag when a selected match clears the counter from 0xFF. A random phase compares every read-back and interrupt value against a cycle model built from the requirements.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int W      = 8;
    localparam int ADDR_W = 3;
    localparam int NEV    = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPA  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMPB  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;

    localparam logic [W-1:0] CTRL_MASK = 8'hF8;

    localparam logic [1:0] CLR_NONE = 2'd0;
    localparam logic [1:0] CLR_A    = 2'd1;
    localparam logic [1:0] CLR_B    = 2'd2;
    localparam logic [1:0] CLR_EXT  = 2'd3;

    typedef struct packed {
        logic [W-1:0]   ctrl;
        logic           lvl_mode;
        logic [W-1:0]   cnt;
        logic [W-1:0]   cmpa;
        logic [W-1:0]   cmpb;
        logic [NEV-1:0] flags;
    } dct_state_t;
endpackage

// File: rtl/dct_sync.sv
module dct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-2:0], pin};
        prev_d = sh_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign lvl  = sh_q[STAGES-1];
    assign rise = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dct_count.sv
module dct_count
    import dct_pkg::*;
(
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] cmpa,
    input  logic [W-1:0] cmpb,
    input  logic         tick,
    input  logic [1:0]   sel,
    input  logic         ext_hit,
    input  logic         wr_cnt,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_d,
    output logic         ev_ovf,
    output logic         ev_cma,
    output logic         ev_cmb
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic sel_hit;

    always_comb begin
        ev_cma  = tick && (cnt_q == cmpa);
        ev_cmb  = tick && (cnt_q == cmpb);
        sel_hit = ((sel == CLR_A) && ev_cma) || ((sel == CLR_B) && ev_cmb);
        ev_ovf  = tick && (cnt_q == TOP) && !wr_cnt && !ext_hit && !sel_hit;

        if (wr_cnt)       cnt_d = wdata;
        else if (ext_hit) cnt_d = '0;
        else if (tick)    cnt_d = sel_hit ? '0 : cnt_q + 1'b1;
        else              cnt_d = cnt_q;
    end
endmodule

// File: rtl/dct_flags.sv
module dct_flags #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags_q,
    input  logic [N-1:0] set,
    input  logic         wr,
    input  logic [N-1:0] keep,
    output logic [N-1:0] flags_d
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            flags_d[i] = (flags_q[i] && !(wr && !keep[i])) || set[i];
        end
    end
endmodule

// File: rtl/dct_timer.sv
module dct_timer
    import dct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              tick,
    input  logic              ext_clr,
    output logic              irq_ovf,
    output logic              irq_cma,
    output logic              irq_cmb
);
    dct_state_t st_d, st_q;

    logic           ext_lvl, ext_rise, ext_hit, wr_cnt, wr_flags;
    logic [1:0]     sel;
    logic [W-1:0]   cnt_nx;
    logic [NEV-1:0] ev, flags_nx;
    logic           ev_ovf, ev_cma, ev_cmb;

    dct_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_clr),
        .lvl  (ext_lvl),
        .rise (ext_rise)
    );

    assign sel      = st_q.ctrl[4:3];
    assign ext_hit  = (sel == CLR_EXT) && (st_q.lvl_mode ? ext_lvl : ext_rise);
    assign wr_cnt   = reg_wr && (reg_addr == A_CNT);
    assign wr_flags = reg_wr && (reg_addr == A_FLAGS);

    dct_count i_count (
        .cnt_q  (st_q.cnt),
        .cmpa   (st_q.cmpa),
        .cmpb   (st_q.cmpb),
        .tick   (tick),
        .sel    (sel),
        .ext_hit(ext_hit),
        .wr_cnt (wr_cnt),
        .wdata  (reg_wdata),
        .cnt_d  (cnt_nx),
        .ev_ovf (ev_ovf),
        .ev_cma (ev_cma),
        .ev_cmb (ev_cmb)
    );

    assign ev = {ev_cmb, ev_cma, ev_ovf};

    dct_flags #(.N(NEV)) i_flags (
        .flags_q(st_q.flags),
        .set    (ev),
        .wr     (wr_flags),
        .keep   (reg_wdata[NEV-1:0]),
        .flags_d(flags_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.cnt   = cnt_nx;
        st_d.flags = flags_nx;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL:  st_d.ctrl     = reg_wdata & CTRL_MASK;
                A_MODE:  st_d.lvl_mode = reg_wdata[0];
                A_CMPA:  st_d.cmpa     = reg_wdata;
                A_CMPB:  st_d.cmpb     = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = st_q.ctrl;
            A_MODE:  reg_rdata = {{(W-1){1'b0}}, st_q.lvl_mode};
            A_CNT:   reg_rdata = st_q.cnt;
            A_CMPA:  reg_rdata = st_q.cmpa;
            A_CMPB:  reg_rdata = st_q.cmpb;
            A_FLAGS: reg_rdata = {{(W-NEV){1'b0}}, st_q.flags};
            default: reg_rdata = '0;
        endcase
    end

    assign irq_ovf = st_q.flags[0] & st_q.ctrl[5];
    assign irq_cma = st_q.flags[1] & st_q.ctrl[6];
    assign irq_cmb = st_q.flags[2] & st_q.ctrl[7];
endmodule

// File: rtl/dct_checker.sv
module dct_checker
    import dct_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic              irq_ovf,
    input logic              irq_cma,
    input logic              irq_cmb,
    input logic [W-1:0]      ctrl,
    input logic              lvl_mode,
    input logic [W-1:0]      cnt,
    input logic [W-1:0]      cmpa,
    input logic [W-1:0]      cmpb,
    input logic              ext_lvl,
    input logic              ext_rise
);
    logic wrc, extc;
    assign wrc  = reg_wr && (reg_addr == A_CNT);
    assign extc = (ctrl[4:3] == CLR_EXT) && (lvl_mode ? ext_lvl : ext_rise);

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wrc |=> cnt == $past(reg_wdata));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wrc && !extc) |=> $stable(cnt));

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == 8'hFF && ctrl[4:3] == CLR_NONE && !wrc) |=> cnt == 8'h00);

    a_r6_clear_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl[4:3] == CLR_A && cnt == cmpa && !wrc) |=> cnt == 8'h00);

    a_r6_clear_on_b: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl[4:3] == CLR_B && cnt == cmpb && !wrc) |=> cnt == 8'h00);

    a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[4:3] == CLR_EXT && lvl_mode && ext_lvl && !wrc) |=> cnt == 8'h00);

    a_r9_mask_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[5] |-> !irq_ovf);

    a_r9_mask_cma: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[6] |-> !irq_cma);

    a_r9_mask_cmb: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[7] |-> !irq_cmb);
endmodule

bind dct_timer dct_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq_ovf  (irq_ovf),
    .irq_cma  (irq_cma),
    .irq_cmb  (irq_cmb),
    .ctrl     (st_q.ctrl),
    .lvl_mode (st_q.lvl_mode),
    .cnt      (st_q.cnt),
    .cmpa     (st_q.cmpa),
    .cmpb     (st_q.cmpb),
    .ext_lvl  (ext_lvl),
    .ext_rise (ext_rise)
);

// File: tb/test_dct_timer.sv
module test_dct_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tick = 1'b0;
    logic       ext_clr = 1'b0;
    logic       irq_ovf, irq_cma, irq_cmb;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dct_timer i_dct_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .ext_clr(ext_clr), .irq_ovf(irq_ovf), .irq_cma(irq_cma), .irq_cmb(irq_cmb)
    );

    // Cycle model written from the requirements
    logic [7:0] m_ctrl, m_cnt, m_cma, m_cmb;
    logic       m_mode, m_s1, m_s2, m_prev;
    logic [2:0] m_flg;

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return {7'b0, m_mode};
            3'd2: return m_cnt;
            3'd3: return m_cma;
            3'd4: return m_cmb;
            3'd5: return {5'b0, m_flg};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd2: return "R3";
            3'd5: return "R10";
            default: return "R1";
        endcase
    endfunction

    always @(posedge clk) begin
        logic wrc, extc, ma, mb, sclr, ov;
        logic [2:0] f;
        if (!rst_n) begin
            m_ctrl <= 0; m_cnt <= 0; m_cma <= 0; m_cmb <= 0;
            m_mode <= 0; m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flg <= 0;
        end else begin
            wrc  = reg_wr && reg_addr == 3'd2;
            extc = m_ctrl[4:3] == 2'd3 && (m_mode ? m_s2 : (m_s2 && !m_prev));
            ma   = tick && m_cnt == m_cma;
            mb   = tick && m_cnt == m_cmb;
            sclr = (m_ctrl[4:3] == 2'd1 && ma) || (m_ctrl[4:3] == 2'd2 && mb);
            ov   = tick && m_cnt == 8'hFF && !wrc && !extc && !sclr;
            if (wrc)       m_cnt <= reg_wdata;
            else if (extc) m_cnt <= 0;
            else if (tick) m_cnt <= sclr ? 8'h00 : m_cnt + 8'd1;
            f = m_flg;
            if (reg_wr && reg_addr == 3'd5) f = f & reg_wdata[2:0];
            m_flg <= f | {mb, ma, ov};
            if (reg_wr && reg_addr == 3'd0) m_ctrl <= reg_wdata & 8'hF8;
            if (reg_wr && reg_addr == 3'd1) m_mode <= reg_wdata[0];
            if (reg_wr && reg_addr == 3'd3) m_cma <= reg_wdata;
            if (reg_wr && reg_addr == 3'd4) m_cmb <= reg_wdata;
            m_s1 <= ext_clr; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare read-back and interrupts with the model
    task automatic cyc(input logic wr, input logic [2:0] a, input logic [7:0] d,
                       input logic tk, input logic ex);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; tick = tk; ext_clr = ex;
        #1;
        check(tag_of(a), reg_rdata, m_read(a));
        check("R9", {5'b0, irq_cmb, irq_cma, irq_ovf},
              {5'b0, m_flg[2] & m_ctrl[7], m_flg[1] & m_ctrl[6], m_flg[0] & m_ctrl[5]});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, ext_clr);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'h00, 1'b1, ext_clr);
    endtask

    task automatic idle(input int n, input logic ex);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'h00, 1'b0, ex);
    endtask

    // Read with no side effect and compare against a directed constant
    task automatic expect_rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a; tick = 1'b0;
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) expect_rd("R1", 3'(a), 8'h00);
        check("R1", {5'b0, irq_cmb, irq_cma, irq_ovf}, 8'h00);

        // R2 reserved control bits
        wr(3'd0, 8'hFF);
        expect_rd("R2", 3'd0, 8'hF8);
        wr(3'd0, 8'h07);
        expect_rd("R2", 3'd0, 8'h00);

        // R3 counting and holding
        wr(3'd2, 8'h10);
        ticks(3);
        idle(2, 1'b0);
        expect_rd("R3", 3'd2, 8'h13);

        // R4 wrap with overflow enabled, R9 interrupt
        wr(3'd3, 8'h40); wr(3'd4, 8'h40);
        wr(3'd0, 8'h20);
        wr(3'd2, 8'hFE);
        ticks(2);
        expect_rd("R4", 3'd2, 8'h00);
        expect_rd("R4", 3'd5, 8'h01);
        check("R9", {7'b0, irq_ovf}, 8'h01);

        // R10 write-one keeps, write-zero clears
        wr(3'd5, 8'h07);
        expect_rd("R10", 3'd5, 8'h01);
        wr(3'd5, 8'h00);
        expect_rd("R10", 3'd5, 8'h00);
        check("R9", {7'b0, irq_ovf}, 8'h00);

        // R10 event wins over a same-cycle clear write
        wr(3'd2, 8'hFF);
        cyc(1'b1, 3'd5, 8'h00, 1'b1, 1'b0);
        expect_rd("R10", 3'd5, 8'h01);
        wr(3'd5, 8'h00);

        // R5 flags set while interrupts masked
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h05); wr(3'd4, 8'h06);
        wr(3'd2, 8'h05);
        ticks(2);
        expect_rd("R5", 3'd5, 8'h06);
        check("R5", {5'b0, irq_cmb, irq_cma, irq_ovf}, 8'h00);
        wr(3'd5, 8'h00);

        // R6 clear on match A, period compare+1
        wr(3'd0, 8'h48);
        wr(3'd3, 8'h03);
        wr(3'd2, 8'h00);
        ticks(4);
        expect_rd("R6", 3'd2, 8'h00);
        expect_rd("R6", 3'd5, 8'h02);
        check("R9", {7'b0, irq_cma}, 8'h01);
        ticks(2);
        expect_rd("R6", 3'd2, 8'h02);
        wr(3'd5, 8'h00);

        // R6 clear from 0xFF by match A is not an overflow
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hFE);
        ticks(2);
        expect_rd("R6", 3'd2, 8'h00);
        expect_rd("R6", 3'd5, 8'h02);
        wr(3'd5, 8'h00);

        // R6 clear on match B
        wr(3'd0, 8'h90);
        wr(3'd4, 8'h02);
        wr(3'd2, 8'h00);
        ticks(3);
        expect_rd("R6", 3'd2, 8'h00);
        check("R9", {7'b0, irq_cmb}, 8'h01);
        wr(3'd5, 8'h00);

        // R7 edge mode: one clear, counting continues with pin high
        wr(3'd0, 8'h18); wr(3'd1, 8'h00);
        wr(3'd4, 8'h80); wr(3'd3, 8'h80);
        wr(3'd2, 8'h10);
        idle(5, 1'b1);
        expect_rd("R7", 3'd2, 8'h00);
        ticks(3);
        expect_rd("R7", 3'd2, 8'h03);
        idle(4, 1'b0);

        // R8 level mode: held at zero while high
        wr(3'd1, 8'h01);
        idle(4, 1'b1);
        ticks(3);
        expect_rd("R8", 3'd2, 8'h00);
        idle(4, 1'b0);
        ticks(2);
        expect_rd("R8", 3'd2, 8'h02);

        // R11 write beats tick and level clear
        ext_clr = 1'b1;
        idle(4, 1'b1);
        cyc(1'b1, 3'd2, 8'h80, 1'b1, 1'b1);
        expect_rd("R11", 3'd2, 8'h80);
        idle(4, 1'b0);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h05);
        cyc(1'b1, 3'd2, 8'h33, 1'b1, 1'b0);
        expect_rd("R11", 3'd2, 8'h33);

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            logic w, tk, ex;
            logic [2:0] a;
            logic [7:0] d;
            w  = ($urandom % 4) == 0;
            a  = 3'($urandom % 7);
            d  = 8'($urandom);
            if (a == 3'd2 && d[0]) d = 8'hF0 | d;
            tk = ($urandom % 2) == 0;
            ex = (($urandom % 16) == 0) ? ~ext_clr : ext_clr;
            cyc(w, a, d, tk, ex);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule